// File: doc/BRIEF.md
# Dual-Die Flash Request Sequencer

This block sits on the host side of a serial NOR flash controller whose package holds two identical dies behind one chip select. Both dies decode every command, so a command lands on a single die only when it carries a 4-byte address. The sequencer accepts high-level requests over a valid/ready port and turns each one into an ordered stream of command descriptors. Each descriptor carries an opcode, a 32-bit address and a byte count. A downstream serial engine executes the descriptors.

The sequencer keeps every command die-correct:

- A linear read that runs past the die boundary is split into two reads.
- A whole-chip erase becomes one addressed erase per die. The second erase waits until status reports for the first die show it idle.
- A configuration write is sent to each die in turn.
- A status poll goes to the address of the most recent program or erase.

Requests that are malformed or out of range are refused with a one-cycle error pulse, and no command is issued for them.

Top module: `dual_die_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` is 0 and `req_err` is 0.
- R2: Request kinds are encoded on `req_kind` as follows: 0 read, 1 program, 2 sector erase, 3 chip erase, 4 status poll, 5 configuration write. A request is refused if any of these holds:
  - its kind is 6 or 7;
  - it is a read or program whose length is zero;
  - it is a read or program whose start plus length exceeds 2^ADDR_W bytes;
  - it is a program whose bytes span both dies.
  For a refused request, `req_err` is 1 for exactly the cycle after acceptance, and no descriptor is produced.
- R3: A read that lies within one die produces a single descriptor: opcode 13h, the start address, and count equal to the length.
- R4: A read that starts in the low die and ends in the high die produces two descriptors, with B = 2^(ADDR_W-1). The first is (13h, start, B-start). The second is (13h, B, length-(B-start)).
- R5: A program produces (12h, start, length). A sector erase produces (DCh, start, 0).
- R6: A chip erase proceeds in this order:
  - It first emits (FEh, 0, 0).
  - It then emits status polls (65h, 0, 1). A further poll follows each status report with `stat_busy`=1.
  - After a report with `stat_busy`=0, it emits (FEh, B, 0).
  Opcodes 60h and C7h are never emitted.
- R7: A status poll request produces (65h, A, 1). A is the address of the last program, sector-erase or chip-erase descriptor, or 0 if there has been none since reset.
- R8: A configuration write produces (71h, address with bit ADDR_W-1 cleared, 1), followed by (71h, address with bit ADDR_W-1 set, 1).
- R9: While `cmd_valid` is high and `cmd_ready` is low, the descriptor fields stay unchanged. `req_ready` stays low from acceptance until the last descriptor of the request has been handed off.
- R10: Descriptor address bits above ADDR_W-1 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 3 | Request kind code |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Length in bytes |
| req_err | output | 1 | One-cycle pulse for a refused request |
| cmd_valid | output | 1 | Descriptor present |
| cmd_ready | input | 1 | Descriptor taken by serial engine |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | 32 | 4-byte command address |
| cmd_cnt | output | ADDR_W+1 | Data byte count |
| stat_valid | input | 1 | Status report from a poll |
| stat_busy | input | 1 | Reported die is busy |

## Verification
The bench builds the block with its default ADDR_W of 27, so it covers the full 1-Gbit space. With that width the die boundary sits at 0x4000000, and the length port is wide enough to hold the whole space. At this width the bench can exercise:
- reads that end exactly at the boundary or at the top byte;
- refusal of a request that overruns the space by one byte;
- a program spanning the boundary;
- a chip erase whose busy wait lasts more than one poll.

// File: rtl/ddseq_pkg.sv
package ddseq_pkg;
    typedef enum logic [2:0] {
        K_READ   = 3'd0,
        K_PROG   = 3'd1,
        K_SERASE = 3'd2,
        K_CERASE = 3'd3,
        K_POLL   = 3'd4,
        K_CFGWR  = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EMIT = 2'd1,
        S_WAIT = 2'd2
    } seq_st_e;

    localparam logic [7:0] OP_READ4    = 8'h13;
    localparam logic [7:0] OP_PROG4    = 8'h12;
    localparam logic [7:0] OP_SERASE4  = 8'hDC;
    localparam logic [7:0] OP_DIE_ERASE = 8'hFE;
    localparam logic [7:0] OP_REG_RD   = 8'h65;
    localparam logic [7:0] OP_REG_WR   = 8'h71;
endpackage

// File: rtl/ddseq_req_check.sv
module ddseq_req_check
    import ddseq_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic [2:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              ok
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] SPACE = SUM_W'(1) << ADDR_W;
    localparam logic [SUM_W-1:0] HALF  = SUM_W'(1) << (ADDR_W - 1);

    logic [SUM_W-1:0] span_end;
    logic             zero_len;
    logic             overrun;
    logic             spans_dies;

    always_comb begin
        span_end   = SUM_W'(addr) + SUM_W'(len);
        zero_len   = (len == '0);
        overrun    = (span_end > SPACE);
        spans_dies = !addr[ADDR_W-1] && (span_end > HALF);
        case (kind)
            K_READ:   ok = !zero_len && !overrun;
            K_PROG:   ok = !zero_len && !overrun && !spans_dies;
            K_SERASE, K_CERASE, K_POLL, K_CFGWR: ok = 1'b1;
            default:  ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ddseq_splitter.sv
module ddseq_splitter #(
    parameter int ADDR_W = 27,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              split,
    output logic [LEN_W-1:0]  first_cnt,
    output logic [LEN_W-1:0]  second_cnt
);
    localparam logic [LEN_W-1:0] HALF = LEN_W'(1) << (ADDR_W - 1);

    logic [LEN_W-1:0] to_bound;

    always_comb begin
        to_bound   = HALF - LEN_W'(addr);
        split      = !addr[ADDR_W-1] && (len > to_bound);
        first_cnt  = split ? to_bound : len;
        second_cnt = len - to_bound;
    end
endmodule

// File: rtl/dual_die_seq.sv
module dual_die_seq
    import ddseq_pkg::*;
#(
    parameter int ADDR_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W:0]   req_len,
    output logic              req_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_op,
    output logic [31:0]       cmd_addr,
    output logic [ADDR_W:0]   cmd_cnt,
    input  logic              stat_valid,
    input  logic              stat_busy
);
    localparam int LEN_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] DIE1_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] DIE_MASK  = ~DIE1_BASE;

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        step;
        logic [2:0]        kind;
        logic              split;
        logic [ADDR_W-1:0] nxt_addr;
        logic [LEN_W-1:0]  nxt_cnt;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cnt;
        logic              vld;
        logic              err;
        logic [ADDR_W-1:0] last;
    } seq_t;

    seq_t q, d;

    logic             req_ok;
    logic             sp_split;
    logic [LEN_W-1:0] sp_first;
    logic [LEN_W-1:0] sp_second;

    ddseq_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
        .kind (req_kind),
        .addr (req_addr),
        .len  (req_len),
        .ok   (req_ok)
    );

    ddseq_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_split (
        .addr       (req_addr),
        .len        (req_len),
        .split      (sp_split),
        .first_cnt  (sp_first),
        .second_cnt (sp_second)
    );

    always_comb begin
        d     = q;
        d.err = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (!req_ok) begin
                        d.err = 1'b1;
                    end else begin
                        d.st    = S_EMIT;
                        d.vld   = 1'b1;
                        d.kind  = req_kind;
                        d.step  = 2'd0;
                        d.split = 1'b0;
                        case (req_kind)
                            K_READ: begin
                                d.op       = OP_READ4;
                                d.addr     = req_addr;
                                d.cnt      = sp_first;
                                d.split    = sp_split;
                                d.nxt_addr = DIE1_BASE;
                                d.nxt_cnt  = sp_second;
                            end
                            K_PROG: begin
                                d.op   = OP_PROG4;
                                d.addr = req_addr;
                                d.cnt  = req_len;
                                d.last = req_addr;
                            end
                            K_SERASE: begin
                                d.op   = OP_SERASE4;
                                d.addr = req_addr;
                                d.cnt  = '0;
                                d.last = req_addr;
                            end
                            K_CERASE: begin
                                d.op   = OP_DIE_ERASE;
                                d.addr = '0;
                                d.cnt  = '0;
                                d.last = '0;
                            end
                            K_POLL: begin
                                d.op   = OP_REG_RD;
                                d.addr = q.last;
                                d.cnt  = LEN_W'(1);
                            end
                            default: begin
                                d.op       = OP_REG_WR;
                                d.addr     = req_addr & DIE_MASK;
                                d.cnt      = LEN_W'(1);
                                d.nxt_addr = req_addr | DIE1_BASE;
                            end
                        endcase
                    end
                end
            end
            S_EMIT: begin
                if (cmd_ready) begin
                    d.vld = 1'b0;
                    d.st  = S_IDLE;
                    if (q.kind == K_READ && q.split && q.step == 2'd0) begin
                        d.vld  = 1'b1;
                        d.st   = S_EMIT;
                        d.addr = q.nxt_addr;
                        d.cnt  = q.nxt_cnt;
                        d.step = 2'd1;
                    end else if (q.kind == K_CFGWR && q.step == 2'd0) begin
                        d.vld  = 1'b1;
                        d.st   = S_EMIT;
                        d.addr = q.nxt_addr;
                        d.step = 2'd1;
                    end else if (q.kind == K_CERASE && q.step == 2'd0) begin
                        d.vld  = 1'b1;
                        d.st   = S_EMIT;
                        d.op   = OP_REG_RD;
                        d.addr = '0;
                        d.cnt  = LEN_W'(1);
                        d.step = 2'd1;
                    end else if (q.kind == K_CERASE && q.step == 2'd1) begin
                        d.st = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (stat_valid) begin
                    d.vld = 1'b1;
                    d.st  = S_EMIT;
                    if (!stat_busy) begin
                        d.op   = OP_DIE_ERASE;
                        d.addr = DIE1_BASE;
                        d.cnt  = '0;
                        d.last = DIE1_BASE;
                        d.step = 2'd2;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == S_IDLE);
    assign req_err   = q.err;
    assign cmd_valid = q.vld;
    assign cmd_op    = q.op;
    assign cmd_addr  = {{(32-ADDR_W){1'b0}}, q.addr};
    assign cmd_cnt   = q.cnt;
endmodule

// File: rtl/ddseq_checker.sv
module ddseq_checker #(
    parameter int ADDR_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_err,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [7:0]        cmd_op,
    input logic [31:0]       cmd_addr,
    input logic [ADDR_W:0]   cmd_cnt
);
    localparam int SUM_W = ADDR_W + 2;
    localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (ADDR_W - 1);

    logic [SUM_W-1:0] rd_end;
    logic [SUM_W-1:0] rd_limit;

    always_comb begin
        rd_end   = SUM_W'(cmd_addr[ADDR_W-1:0]) + SUM_W'(cmd_cnt);
        rd_limit = cmd_addr[ADDR_W-1] ? (HALF << 1) : HALF;
    end

    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
                                    && $stable(cmd_addr) && $stable(cmd_cnt));

    a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    a_r6_no_legacy_erase: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != 8'h60 && cmd_op != 8'hC7));

    a_r2_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !cmd_valid && req_ready);

    a_r4_read_one_die: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 8'h13 |-> rd_end <= rd_limit);

    a_r8_cfg_pair: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op == 8'h71 && !cmd_addr[ADDR_W-1]
        |=> cmd_valid && cmd_op == 8'h71 && cmd_addr[ADDR_W-1]);

    a_r10_addr_width: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_addr[31:ADDR_W] == '0);
endmodule

bind dual_die_seq ddseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_err   (req_err),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_cnt   (cmd_cnt)
);

// File: tb/dual_die_seq_test.sv
module dual_die_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 27;
    localparam logic [31:0] B = 32'h0400_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [AW:0]   req_len = '0;
    logic          req_err;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [7:0]    cmd_op;
    logic [31:0]   cmd_addr;
    logic [AW:0]   cmd_cnt;
    logic          stat_valid = 1'b0;
    logic          stat_busy = 1'b0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_die_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_cnt(cmd_cnt), .stat_valid(stat_valid), .stat_busy(stat_busy)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_req(input logic [2:0] k, input logic [31:0] a, input logic [31:0] l);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a[AW-1:0];
        req_len   = l[AW:0];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input logic [7:0] op, input logic [31:0] a, input logic [31:0] c);
        for (int n = 0; n < 20 && !cmd_valid; n++) @(negedge clk);
        chk(req, "cmd_valid", cmd_valid, 1);
        chk(req, "cmd_op", cmd_op, op);
        chk(req, "cmd_addr", cmd_addr, a);
        chk(req, "cmd_cnt", cmd_cnt, c);
        cmd_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        chk(req, "idle cmd_valid", cmd_valid, 0);
        chk(req, "idle req_ready", req_ready, 1);
    endtask

    task automatic send_stat(input logic busy);
        @(negedge clk);
        stat_valid = 1'b1;
        stat_busy  = busy;
        @(posedge clk);
        @(negedge clk);
        stat_valid = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "cmd_valid", cmd_valid, 0);
        chk("R1", "req_err", req_err, 0);
    endtask

    task automatic test_poll_after_reset();
        send_req(3'd4, 32'h123, 0);
        expect_cmd("R7", 8'h65, 32'h0, 1);
        expect_idle("R7");
    endtask

    task automatic test_reads();
        send_req(3'd0, 32'h100, 64);
        expect_cmd("R3", 8'h13, 32'h100, 64);
        expect_idle("R3");
        send_req(3'd0, B - 8, 8);
        expect_cmd("R3", 8'h13, B - 8, 8);
        expect_idle("R3");
        send_req(3'd0, 32'h07FF_FFFC, 4);
        expect_cmd("R3", 8'h13, 32'h07FF_FFFC, 4);
        expect_idle("R3");
        send_req(3'd0, B - 16, 48);
        expect_cmd("R4", 8'h13, B - 16, 16);
        expect_cmd("R4", 8'h13, B, 32);
        expect_idle("R4");
    endtask

    task automatic refuse(input logic [2:0] k, input logic [31:0] a, input logic [31:0] l);
        send_req(k, a, l);
        chk("R2", "req_err", req_err, 1);
        chk("R2", "cmd_valid", cmd_valid, 0);
        @(negedge clk);
        chk("R2", "req_err drop", req_err, 0);
        expect_idle("R2");
    endtask

    task automatic test_refusals();
        refuse(3'd0, 32'h40, 0);
        refuse(3'd0, 32'h07FF_FFFC, 5);
        refuse(3'd1, B - 2, 4);
        refuse(3'd7, 32'h0, 4);
        refuse(3'd1, 32'h10, 0);
    endtask

    task automatic test_program_erase();
        send_req(3'd1, 32'h5000, 256);
        expect_cmd("R5", 8'h12, 32'h5000, 256);
        send_req(3'd4, 32'h0, 0);
        expect_cmd("R7", 8'h65, 32'h5000, 1);
        send_req(3'd2, B + 32'h2_0000, 0);
        expect_cmd("R5", 8'hDC, B + 32'h2_0000, 0);
        send_req(3'd4, 32'h0, 0);
        expect_cmd("R7", 8'h65, B + 32'h2_0000, 1);
        expect_idle("R5");
    endtask

    task automatic test_chip_erase();
        send_req(3'd3, 32'h0, 0);
        expect_cmd("R6", 8'hFE, 32'h0, 0);
        expect_cmd("R6", 8'h65, 32'h0, 1);
        chk("R6", "wait cmd_valid", cmd_valid, 0);
        chk("R9", "wait req_ready", req_ready, 0);
        send_stat(1'b1);
        expect_cmd("R6", 8'h65, 32'h0, 1);
        repeat (3) @(negedge clk);
        chk("R6", "still waiting", cmd_valid, 0);
        send_stat(1'b0);
        expect_cmd("R6", 8'hFE, B, 0);
        expect_idle("R6");
        send_req(3'd4, 32'h0, 0);
        expect_cmd("R7", 8'h65, B, 1);
    endtask

    task automatic test_cfg_write();
        send_req(3'd5, B | 32'h3, 0);
        expect_cmd("R8", 8'h71, 32'h3, 1);
        expect_cmd("R8", 8'h71, B | 32'h3, 1);
        expect_idle("R8");
    endtask

    task automatic test_stall();
        send_req(3'd0, 32'h200, 10);
        repeat (3) begin
            @(negedge clk);
            chk("R9", "stall valid", cmd_valid, 1);
            chk("R9", "stall addr", cmd_addr, 32'h200);
            chk("R9", "stall cnt", cmd_cnt, 10);
            chk("R9", "stall ready", req_ready, 0);
        end
        expect_cmd("R9", 8'h13, 32'h200, 10);
        expect_idle("R9");
        send_stat(1'b0);
        chk("R6", "idle stat ignored", cmd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_poll_after_reset();
        test_reads();
        test_refusals();
        test_program_erase();
        test_chip_erase();
        test_cfg_write();
        test_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule